// File: doc/BRIEF.md
# Synchronous burst clock and latency generator

This block drives the memory-side clock for a synchronous burst access and times the first data beat. When idle it holds the memory clock low. A start request starts an access. The block then captures three settings: the divide setting, the latency setting and the burst flag. It produces a memory clock whose period is a programmed number of kernel clock cycles. It raises an address-valid strobe for the first memory clock period only, because the address hold in synchronous mode is always one memory clock period.

Latency is counted in memory clock periods, not in kernel cycles. With burst enabled, the first beat is valid on the rising edge that lies latency setting plus two periods after the access starts. A one-kernel-cycle data-ready pulse marks that edge. With burst disabled, the latency setting is ignored and the beat follows the address period directly. Busy covers the whole access and ends with the period that carries the first beat. The burst data path and the asynchronous timing settings are handled elsewhere.

Top module: `burst_clk_lat_gen`

## Requirements
- R1: After reset, mclk, addr_vld, data_rdy and busy are all 0.
- R2: While busy is 0, mclk, addr_vld and data_rdy stay 0. A start request seen while busy is 1 is ignored.
- R3: The mclk period is div+1 kernel cycles (div is 4 bits, 0 to 15). Each period starts high and stays high for ceil((div+1)/2) kernel cycles. With div=0, mclk passes the kernel clock through while busy.
- R4: A start sampled with busy at 0 sets busy on that edge. The first mclk period begins in the same kernel cycle, and addr_vld is 1 for exactly that first period.
- R5: With burst_en=1, data_rdy is 1 for exactly one kernel cycle. That cycle is the first cycle of mclk period index lat+2, counting the first period as index 0 and with lat 4 bits, so the index runs from 2 to 17.
- R6: With burst_en=0, data_rdy pulses in the first cycle of period index 1, whatever lat is.
- R7: Busy lasts (T+1)*(div+1) kernel cycles, where T is the period index of data_rdy. If start is held at 1, a new access begins on the edge right after busy falls.
- R8: div, lat and burst_en are captured when the access starts. Changes to them while busy is 1 have no effect on that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Access request |
| div | input | 4 | Clock divide setting (period = div+1 kernel cycles) |
| lat | input | 4 | First-data latency setting (lat+2 memory clock periods) |
| burst_en | input | 1 | Burst mode enable for this access |
| mclk | output | 1 | Memory clock output |
| addr_vld | output | 1 | Address-valid strobe, first memory clock period |
| data_rdy | output | 1 | One-cycle pulse marking the first valid beat |
| busy | output | 1 | Access in progress |

## Verification
Two situations are hard to reach from the ports. The first is an access with the largest divide and largest latency settings together: it runs 288 kernel cycles, so the bench waits on busy and does not use a fixed delay. The second is a change to the settings, plus a second start, placed in the middle of an access. The bench does this by rewriting div, lat and burst_en and pulsing start one cycle after acceptance, while the model keeps the captured values. A third case holds start high across the end of an access to show the back-to-back restart.

// File: rtl/burst_clk_lat_gen.sv
module burst_clk_lat_gen #(
  parameter int DW = 4,
  parameter int LW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] div,
  input  logic [LW-1:0] lat,
  input  logic          burst_en,
  output logic          mclk,
  output logic          addr_vld,
  output logic          data_rdy,
  output logic          busy
);
  localparam int RW = LW + 1;

  logic [DW-1:0] div_q, ph;
  logic [RW-1:0] rem;
  logic          first;

  wire [DW:0] hi_len  = ({1'b0, div_q} + 2'd2) >> 1;
  wire        per_end = (ph == div_q);
  wire        in_hi   = ({1'b0, ph} < hi_len);

  assign mclk     = busy & ((div_q == '0) ? clk : in_hi);
  assign addr_vld = busy & first;
  assign data_rdy = busy & (ph == '0) & (rem == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      first <= 1'b0;
      div_q <= '1;
      ph    <= '0;
      rem   <= '0;
    end else if (!busy) begin
      if (start) begin
        busy  <= 1'b1;
        first <= 1'b1;
        div_q <= div;
        ph    <= '0;
        rem   <= burst_en ? RW'(lat) + RW'(2) : RW'(1);
      end
    end else if (per_end) begin
      ph    <= '0;
      first <= 1'b0;
      if (rem == '0) busy <= 1'b0;
      else           rem  <= rem - 1'b1;
    end else begin
      ph <= ph + 1'b1;
    end
  end
endmodule

module burst_clk_lat_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic mclk,
  input logic addr_vld,
  input logic data_rdy,
  input logic busy
);
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mclk && !addr_vld && !data_rdy));
  p_addr_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> addr_vld);
  p_rdy_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    data_rdy |=> !data_rdy);
  p_rdy_after_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    data_rdy |-> !addr_vld);
  p_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> busy);
endmodule

bind burst_clk_lat_gen burst_clk_lat_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .mclk(mclk),
  .addr_vld(addr_vld), .data_rdy(data_rdy), .busy(busy)
);

// File: tb/burst_clk_lat_gen_test.sv
module burst_clk_lat_gen_test;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, burst_en = 1'b0;
  logic [3:0] div = 4'd0, lat = 4'd0;
  logic mclk, addr_vld, data_rdy, busy;

  int errors = 0, checks = 0, cycles = 0;
  bit cmp_on = 0;
  string scen = "R1";

  int m_busy = 0, m_k = 0, m_d = 0, m_t = 0, m_be = 0;

  always #4 clk = ~clk;

  burst_clk_lat_gen uut (
    .clk(clk), .rst_n(rst_n), .start(start), .div(div), .lat(lat),
    .burst_en(burst_en), .mclk(mclk), .addr_vld(addr_vld),
    .data_rdy(data_rdy), .busy(busy)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s [%s] t=%0t actual=%0d expected=%0d", req, scen, $time, act, exp);
    end
  endtask

  always @(posedge clk) begin
    int per, ph, idx, e_mclk, e_av, e_dr;
    cycles++;
    if (!rst_n) begin
      m_busy = 0; m_k = 0;
    end else if (m_busy == 0) begin
      if (start) begin
        m_busy = 1; m_k = 0; m_d = div; m_be = burst_en;
        m_t = burst_en ? lat + 2 : 1;
      end
    end else begin
      if (m_k == (m_t + 1) * (m_d + 1) - 1) m_busy = 0;
      else m_k++;
    end
    #2;
    if (cmp_on) begin
      per = m_d + 1; ph = m_k % per; idx = m_k / per;
      e_mclk = m_busy && (m_d == 0 ? 1 : (ph < (m_d + 2) / 2));
      e_av   = m_busy && idx == 0;
      e_dr   = m_busy && ph == 0 && idx == m_t;
      chk("R7 busy", busy, m_busy);
      chk(m_busy ? "R3 mclk" : "R2 mclk", mclk, e_mclk);
      chk("R4 addr_vld", addr_vld, e_av);
      chk(m_be ? "R5 data_rdy" : "R6 data_rdy", data_rdy, e_dr);
    end
  end

  initial begin
    wait (cycles > 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic run(input string tag, input int d, input int l, input int be, input bit corrupt);
    scen = tag;
    @(negedge clk);
    div = 4'(d); lat = 4'(l); burst_en = be[0]; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (corrupt) begin
      div = ~div; lat = ~lat; burst_en = ~burst_en; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #1;
    checks++; if (mclk || addr_vld || data_rdy || busy) begin
      errors++; $display("FAIL R1 reset outputs actual=%b%b%b%b expected=0000", mclk, addr_vld, data_rdy, busy);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cmp_on = 1;
    run("R3 div0", 0, 0, 1, 0);
    run("R3 div1", 1, 3, 1, 0);
    run("R3 div2", 2, 0, 1, 0);
    run("R5 max", 15, 15, 1, 0);
    run("R6 noburst", 4, 9, 0, 0);
    run("R6 noburst div0", 0, 5, 0, 0);
    run("R8 change", 3, 2, 1, 1);
    run("R8 change nb", 5, 7, 0, 1);
    run("R5 div7", 7, 1, 1, 0);
    scen = "R7 held start";
    @(negedge clk);
    div = 4'd2; lat = 4'd1; burst_en = 1'b1; start = 1'b1;
    repeat (40) @(negedge clk);
    start = 1'b0;
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule